// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block guards a system against hung software. A down-counter runs while the watchdog is enabled. Software must restart it before it runs out. A single control register sets three things: the enable, a time-out period taken from sixteen power-of-two lengths, and the way a time-out is answered.

A time-out is answered in one of two ways. In direct mode it raises a one-cycle system-reset request at once. In staged mode the first time-out raises an interrupt. If that interrupt is still pending at the next time-out, the system-reset request follows.

A set-only lock bit stops software from turning the watchdog off once it runs. A new period is not applied mid-count: it waits for the next restart or time-out. The reset request also acts as the block's own synchronous reset.

Top module: `twostage_watchdog`

## Requirements
- R1: After reset, and for any address other than 0, `regRdata` is 0. At address 0 it reads the control word: EN in bit 0, RSP in bit 1, FRZ in bit 3 and TOP in bits 7:4. Bit 2 and bits 31:8 always read 0, and writes to them have no effect. After reset, `irqOut` and `sysResetOut` are 0 and the counter holds 2^BASE_LOG2.
- R2: While EN is 0 the counter keeps its value and no time-out occurs. While EN is 1 it decrements once per clock.
- R3: With RSP = 0, every time-out pulses `sysResetOut` and leaves `irqOut` alone.
- R4: With RSP = 1, a time-out with no interrupt pending sets `irqOut`. A time-out while the interrupt is pending pulses `sysResetOut`.
- R5: Writing TOP leaves the running count unchanged. The new period is used from the next reload.
- R6: A one-cycle `restartPulse` reloads the counter with the current period and clears a pending interrupt. It takes priority over a time-out in the same cycle.
- R7: FRZ can be set by software but never cleared by it. While FRZ and EN are both 1, a write cannot clear EN.
- R8: `sysResetOut` is high for exactly one cycle. In the following cycle every control field, the pending interrupt and the counter return to their reset values.
- R9: `irqOut` stays high until an `irqClear` pulse. Clearing it before the next time-out means that time-out raises the interrupt again instead of a reset.
- R10: TOP = n gives a period of 2^(BASE_LOG2+n) cycles. A time-out happens in the cycle in which the count would reach zero, and the counter then reloads from the current TOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register word address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| restartPulse | input | 1 | Counter restart command, one cycle |
| irqClear | input | 1 | Interrupt clear, one cycle |
| irqOut | output | 1 | First-stage interrupt request |
| sysResetOut | output | 1 | System-reset request pulse |

## Verification
The assertions take three things for granted about the inputs. `restartPulse` and `irqClear` arrive as single-cycle pulses. Register writes are single-cycle strobes. The base exponent is large enough that a reload never yields a count of one.

The bench drives every strobe from a negedge for exactly one cycle, and it builds the block with a base exponent of 2. With that base the shortest period is four cycles, so each time-out falls at a cycle the bench can predict.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             load;
    logic             step;
    logic [SEL_W-1:0] loadSel;
  } cntCmd_t;
endpackage

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 16,
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W)
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCmd_t cmd,
  output logic    atLast
);
  logic [CNT_W-1:0] count;

  function automatic logic [CNT_W-1:0] periodOf(input logic [SEL_W-1:0] sel);
    return CNT_W'(1) << (BASE_LOG2 + int'(sel));
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          count <= periodOf('0);
    else if (cmd.load)  count <= periodOf(cmd.loadSel);
    else if (cmd.step)  count <= count - CNT_W'(1);
  end

  assign atLast = (count == CNT_W'(1));

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    count != '0); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.step && !cmd.load) |=> $stable(count)); // R2
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              restartReq,
  input  logic              irqClear,
  input  logic              atLast,
  output cntCmd_t           cmd,
  output logic              irqOut,
  output logic              sysResetOut
);
  logic             en, rsp, frz, irqPend, rstPulse;
  logic [SEL_W-1:0] top;
  logic             hit, softRst, tmo;

  assign hit     = regWe && (regAddr == '0);
  assign softRst = rstPulse;
  assign tmo     = en && atLast && !restartReq && !softRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en <= 1'b0; rsp <= 1'b0; frz <= 1'b0; top <= '0;
      irqPend <= 1'b0; rstPulse <= 1'b0;
    end else if (softRst) begin
      en <= 1'b0; rsp <= 1'b0; frz <= 1'b0; top <= '0;
      irqPend <= 1'b0; rstPulse <= 1'b0;
    end else begin
      rstPulse <= 1'b0;
      if (hit) begin
        en  <= (frz && en) ? 1'b1 : regWdata[0];
        rsp <= regWdata[1];
        frz <= frz | regWdata[3];
        top <= regWdata[7:4];
      end
      if (restartReq)
        irqPend <= 1'b0;
      else if (tmo) begin
        if (!rsp || irqPend) rstPulse <= 1'b1;
        else                 irqPend  <= 1'b1;
      end else if (irqClear)
        irqPend <= 1'b0;
    end
  end

  always_comb begin
    cmd.load    = restartReq || softRst || tmo;
    cmd.step    = en;
    cmd.loadSel = softRst ? '0 : top;
  end

  assign regRdata    = (regAddr == '0) ? {24'b0, top, frz, 1'b0, rsp, en} : 32'b0;
  assign irqOut      = irqPend;
  assign sysResetOut = rstPulse;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sysResetOut |=> !sysResetOut); // R8
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    sysResetOut |=> (regRdata[7:0] == 8'h00) && !irqOut); // R8
  AST_FRZ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (frz && !sysResetOut) |=> frz); // R7
  AST_FRZ_KEEPS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (frz && en && !sysResetOut) |=> en); // R7
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqClear && !restartReq && !sysResetOut) |=> irqOut); // R9
  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysResetOut) |-> $past(en)); // R2
  AST_DIRECT_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (!rsp && !irqOut && !hit) |=> !irqOut); // R3
endmodule

// File: rtl/twostage_watchdog.sv
module twostage_watchdog
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 16,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              restartPulse,
  input  logic              irqClear,
  output logic              irqOut,
  output logic              sysResetOut
);
  cntCmd_t cmd;
  logic    atLast;

  wdog_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .restartReq(restartPulse),
    .irqClear(irqClear), .atLast(atLast), .cmd(cmd),
    .irqOut(irqOut), .sysResetOut(sysResetOut)
  );

  wdog_count #(.BASE_LOG2(BASE_LOG2)) i_count (
    .clk(clk), .rstN(rstN), .cmd(cmd), .atLast(atLast)
  );
endmodule

// File: tb/test_twostage_watchdog.sv
module test_twostage_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int KIND_IRQ = 0;
  localparam int KIND_RST = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        restartPulse = 1'b0;
  logic        irqClear = 1'b0;
  logic        irqOut, sysResetOut;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  typedef struct { int kind; int at; string tag; } expItem_t;
  expItem_t expQ[$];

  twostage_watchdog #(.BASE_LOG2(2), .ADDR_W(4)) i_twostage_watchdog (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .restartPulse(restartPulse),
    .irqClear(irqClear), .irqOut(irqOut), .sysResetOut(sysResetOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops expected events as the design produces them
  logic irqPrev = 1'b0, rstPrev = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (irqOut && !irqPrev) popCompare(KIND_IRQ);
      if (sysResetOut) popCompare(KIND_RST);
      if (sysResetOut && rstPrev) check("R8 pulse width", 2, 1);
    end
    irqPrev = irqOut;
    rstPrev = sysResetOut;
  end

  task automatic popCompare(input int kind);
    expItem_t e;
    if (expQ.size() == 0) begin
      check("unexpected event kind", kind, -1);
      return;
    end
    e = expQ.pop_front();
    check({e.tag, " event kind"}, kind, e.kind);
    check({e.tag, " event cycle"}, cyc, e.at);
  endtask

  task automatic expect_ev(input int kind, input int at, input string tag);
    expItem_t e;
    e.kind = kind; e.at = at; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic wr(input logic [31:0] d, output int k);
    @(negedge clk);
    regWe = 1'b1; regWdata = d;
    @(posedge clk); #1;
    k = cyc;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic waitCyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulseAt(input int c, input bit isRestart);
    waitCyc(c);
    if (isRestart) restartPulse = 1'b1; else irqClear = 1'b1;
    @(negedge clk);
    restartPulse = 1'b0; irqClear = 1'b0;
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while (expQ.size() != 0 && guard < 400) begin @(negedge clk); guard++; end
    check({tag, " queue drained"}, expQ.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      check("watchdog expired", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int k, k2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset read", regRdata, 0);
    check("R1 reset irq", irqOut, 0);
    check("R1 reset sysreset", sysResetOut, 0);

    // R1 reserved bits ignored, other address reads zero
    wr(32'hFFFF_FF06, k);
    check("R1 reserved bits", regRdata, 32'h02);
    regAddr = 4'h1; #1;
    check("R1 other address", regRdata, 0);
    regAddr = 4'h0;
    wr(32'h0, k);

    // R2 disabled: long idle, then enable; count still full (4)
    repeat (40) @(negedge clk);
    // R2 partial count then disable: holds remaining 2
    wr(32'h01, k);
    wr(32'h00, k2);
    repeat (20) @(negedge clk);
    wr(32'h01, k);
    expect_ev(KIND_RST, k + 2, "R2 hold");
    drain("R2");
    check("R8 fields cleared", regRdata, 0);

    // R3 and R5: direct mode, TOP=1 written, first timeout uses old count 4
    wr(32'h11, k);
    expect_ev(KIND_RST, k + 4, "R3/R5 direct");
    drain("R3");
    check("R8 cleared after direct", regRdata, 0);

    // R4, R10: staged; irq at 4, reload period 8, reset at +8
    wr(32'h13, k);
    expect_ev(KIND_IRQ, k + 4, "R4 first stage");
    expect_ev(KIND_RST, k + 12, "R4/R10 second stage");
    drain("R4");
    check("R8 irq cleared", irqOut, 0);

    // R9: clear before second timeout re-raises irq instead of reset
    wr(32'h03, k);
    expect_ev(KIND_IRQ, k + 4, "R9 first");
    expect_ev(KIND_IRQ, k + 8, "R9 re-raise");
    expect_ev(KIND_RST, k + 12, "R9 final");
    pulseAt(k + 5, 1'b0);
    check("R9 irq cleared", irqOut, 0);
    drain("R9");

    // R6: restart reloads with new TOP=2 (16) at edge k+2
    wr(32'h21, k);
    expect_ev(KIND_RST, k + 18, "R6/R10 restart");
    pulseAt(k + 1, 1'b1);
    drain("R6");

    // R6: restart clears pending irq
    wr(32'h03, k);
    expect_ev(KIND_IRQ, k + 4, "R6 irq");
    expect_ev(KIND_IRQ, k + 10, "R6 irq after restart");
    expect_ev(KIND_RST, k + 14, "R6 final");
    pulseAt(k + 5, 1'b1);
    check("R6 irq cleared by restart", irqOut, 0);
    drain("R6b");

    // R7: FRZ set-only while disabled, then locks EN
    wr(32'h08, k);
    wr(32'h00, k);
    check("R7 frz not clearable", regRdata, 32'h08);
    wr(32'h01, k);
    wr(32'h00, k2);
    check("R7 en locked", regRdata, 32'h09);
    expect_ev(KIND_RST, k + 4, "R7 locked timeout");
    drain("R7");
    check("R7 frz cleared by sysreset", regRdata, 0);

    repeat (30) @(negedge clk);
    check("no stray events", expQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule